// File: doc/BRIEF.md
# Handshake Word Crossing from a Fast to a Slow Clock

This block moves an occasional multi-bit word from a fast source clock domain into a slower destination clock domain. The word never passes through a synchronizer. The source latches the word into a holding register and keeps it frozen. Only two single-bit control lines cross the boundary, and each crosses through its own flop chain: a request going forward and an acknowledge coming back.

A transfer has four phases. The source raises its request. The destination sees the synchronized request, samples the frozen word, pulses a valid strobe for one cycle and raises its acknowledge. The source sees the acknowledge and drops its request. The destination sees the request fall and drops its acknowledge. While all of this is in progress the source reports busy and ignores new load strobes. It becomes ready again only when the acknowledge it observes has fallen. Each domain has its own active-low asynchronous reset.

Top module: `hs_bus_xfer`

## Requirements
- R1: While both resets are asserted and after they are released with no load applied, `src_busy_o` is 0, `dst_valid_o` is 0 and `dst_data_o` is all zeros. The request and acknowledge lines are low.
- R2: A `src_load_i` sampled high while `src_busy_o` is low latches `src_data_i`. At the next source clock edge `src_busy_o` goes high. The latched word stays unchanged for as long as `src_busy_o` is high.
- R3: A `src_load_i` sampled high while `src_busy_o` is high has no effect. It produces no extra valid pulse, and the delivered word is the one latched at acceptance.
- R4: The request reaches the destination only through a chain of SYNC_STAGES flops (default 2). Once raised, the request stays high until the acknowledge, after its own SYNC_STAGES-flop chain in the source domain, reads high.
- R5: The destination samples the held word only in the cycle in which the synchronized request reads high and its acknowledge is still low. The sampled word appears on `dst_data_o` together with `dst_valid_o`, and `dst_data_o` holds that value until the next capture.
- R6: Each accepted load produces exactly one `dst_valid_o` pulse, and that pulse lasts exactly one destination clock cycle.
- R7: The destination lowers its acknowledge only after the synchronized request reads low. `src_busy_o` stays high until the synchronized acknowledge reads low. A load presented in the first cycle in which `src_busy_o` is low is accepted.
- R8: With the default chain length, `dst_valid_o` rises no more than 5 destination clock cycles after the source edge that accepted the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source (fast) clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_load_i | input | 1 | Load strobe; a new word is offered |
| src_data_i | input | DATA_W | Word offered with the load strobe |
| src_busy_o | output | 1 | High while a transfer is open; loads are ignored |
| dst_clk | input | 1 | Destination (slow) clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_data_o | output | DATA_W | Last word captured in the destination domain |
| dst_valid_o | output | 1 | One-cycle strobe marking a fresh capture |

## Verification
The hardest case to reach from the ports is a load that lands exactly on the first source cycle after busy falls, while the destination is still idling on a slow clock. The stimulus polls `src_busy_o` at every falling source edge and fires the next load at once, so consecutive transfers sit back to back. Between transfers it also keeps the load strobe high for several cycles with different words while busy. The stimulus steps through word patterns of all zeros, all ones, alternating bits and pseudo-random values, so a leaked junk word or a corrupted capture shows up as a data mismatch at the destination.

// File: rtl/hsx_pkg.sv
package hsx_pkg;

  typedef enum logic [1:0] {
    SRC_IDLE    = 2'd0,
    SRC_REQ     = 2'd1,
    SRC_RELEASE = 2'd2
  } src_state_t;

  // destination cycles from request edge to valid pulse, no metastability
  function automatic int unsigned fwd_latency(input int unsigned stages);
    return stages + 1;
  endfunction

endpackage

// File: rtl/hsx_sync.sv
module hsx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hsx_src.sv
module hsx_src
  import hsx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_sync_i,
  output logic              req_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] word_o,
  output logic              accept_o
);

  src_state_t        state_q;
  logic              req_q;
  logic              busy_q;
  logic [DATA_W-1:0] word_q;

  assign accept_o = load_i && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SRC_IDLE;
      req_q   <= 1'b0;
      busy_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      unique case (state_q)
        SRC_IDLE: begin
          if (accept_o) begin
            word_q  <= data_i;
            req_q   <= 1'b1;
            busy_q  <= 1'b1;
            state_q <= SRC_REQ;
          end
        end
        SRC_REQ: begin
          if (ack_sync_i) begin
            req_q   <= 1'b0;
            state_q <= SRC_RELEASE;
          end
        end
        SRC_RELEASE: begin
          if (!ack_sync_i) begin
            busy_q  <= 1'b0;
            state_q <= SRC_IDLE;
          end
        end
        default: begin
          req_q   <= 1'b0;
          busy_q  <= 1'b0;
          state_q <= SRC_IDLE;
        end
      endcase
    end
  end

  assign req_o  = req_q;
  assign busy_o = busy_q;
  assign word_o = word_q;

endmodule

// File: rtl/hsx_dst.sv
module hsx_dst #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_sync_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              capture_o
);

  logic              ack_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  assign capture_o = req_sync_i && !ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= capture_o;
      if (capture_o) begin
        data_q <= word_i;
        ack_q  <= 1'b1;
      end else if (!req_sync_i && ack_q) begin
        ack_q  <= 1'b0;
      end
    end
  end

  assign ack_o   = ack_q;
  assign valid_o = valid_q;
  assign data_o  = data_q;

endmodule

// File: rtl/hs_bus_xfer.sv
module hs_bus_xfer #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_load_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_busy_o,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic [DATA_W-1:0] dst_data_o,
  output logic              dst_valid_o
);

  // named crossing events, also watched by the bound checker
  logic              src_req;
  logic              src_accept;
  logic              src_ack_seen;
  logic [DATA_W-1:0] src_held_word;
  logic              dst_req_seen;
  logic              dst_ack;
  logic              dst_capture;

  hsx_src #(.DATA_W(DATA_W)) u_src (
    .clk        (src_clk),
    .rst_n      (src_rst_n),
    .load_i     (src_load_i),
    .data_i     (src_data_i),
    .ack_sync_i (src_ack_seen),
    .req_o      (src_req),
    .busy_o     (src_busy_o),
    .word_o     (src_held_word),
    .accept_o   (src_accept)
  );

  hsx_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (dst_clk),
    .rst_n (dst_rst_n),
    .d_i   (src_req),
    .q_o   (dst_req_seen)
  );

  hsx_dst #(.DATA_W(DATA_W)) u_dst (
    .clk        (dst_clk),
    .rst_n      (dst_rst_n),
    .req_sync_i (dst_req_seen),
    .word_i     (src_held_word),
    .ack_o      (dst_ack),
    .data_o     (dst_data_o),
    .valid_o    (dst_valid_o),
    .capture_o  (dst_capture)
  );

  hsx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (src_clk),
    .rst_n (src_rst_n),
    .d_i   (dst_ack),
    .q_o   (src_ack_seen)
  );

endmodule

// File: rtl/hsx_checker.sv
module hsx_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              src_clk,
  input logic              src_rst_n,
  input logic              dst_clk,
  input logic              dst_rst_n,
  input logic              src_load_i,
  input logic              src_busy_o,
  input logic              src_req,
  input logic              src_ack_seen,
  input logic [DATA_W-1:0] src_held_word,
  input logic              dst_req_seen,
  input logic              dst_ack,
  input logic              dst_capture,
  input logic              dst_valid_o,
  input logic [DATA_W-1:0] dst_data_o
);

  AST_RESET_QUIET: assert property (@(posedge src_clk)
    !src_rst_n |-> (!src_busy_o && !src_req)); // R1

  AST_WORD_FROZEN: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_busy_o |=> (!src_busy_o || $stable(src_held_word))); // R2

  AST_LOAD_WHILE_BUSY: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (src_busy_o && src_load_i) |=> $stable(src_held_word)); // R3

  AST_REQ_HELD: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (src_req && !src_ack_seen) |=> src_req); // R4

  AST_REQ_INSIDE_BUSY: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_req |-> src_busy_o); // R4

  AST_CAPTURE_NEEDS_REQ: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $rose(dst_ack) |-> $past(dst_req_seen)); // R5

  AST_DATA_HOLD: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !dst_valid_o |=> (dst_valid_o || $stable(dst_data_o))); // R5

  AST_ONE_CYCLE_VALID: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_valid_o |=> !dst_valid_o); // R6

  AST_ACK_FALL_ON_REQ_LOW: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $fell(dst_ack) |-> !$past(dst_req_seen)); // R7

  AST_BUSY_FALL_ON_ACK_LOW: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $fell(src_busy_o) |-> !$past(src_ack_seen)); // R7

  AST_CAPTURE_ONCE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_capture |=> !dst_capture); // R6

endmodule

bind hs_bus_xfer hsx_checker #(.DATA_W(DATA_W)) u_hsx_checker (
  .src_clk       (src_clk),
  .src_rst_n     (src_rst_n),
  .dst_clk       (dst_clk),
  .dst_rst_n     (dst_rst_n),
  .src_load_i    (src_load_i),
  .src_busy_o    (src_busy_o),
  .src_req       (src_req),
  .src_ack_seen  (src_ack_seen),
  .src_held_word (src_held_word),
  .dst_req_seen  (dst_req_seen),
  .dst_ack       (dst_ack),
  .dst_capture   (dst_capture),
  .dst_valid_o   (dst_valid_o),
  .dst_data_o    (dst_data_o)
);

// File: tb/test_hs_bus_xfer.sv
`timescale 1ns/1ps
module test_hs_bus_xfer;

  localparam int unsigned DW = 16;
  localparam int MAX_LAT = 5;

  logic          src_clk = 1'b0;
  logic          dst_clk = 1'b0;
  logic          src_rst_n = 1'b0;
  logic          dst_rst_n = 1'b0;
  logic          src_load_i = 1'b0;
  logic [DW-1:0] src_data_i = '0;
  logic          src_busy_o;
  logic [DW-1:0] dst_data_o;
  logic          dst_valid_o;

  always #2.5 src_clk = ~src_clk;   // 200 MHz
  always #6.5 dst_clk = ~dst_clk;   // slower destination

  hs_bus_xfer #(.DATA_W(DW), .SYNC_STAGES(2)) i_hs_bus_xfer (
    .src_clk     (src_clk),
    .src_rst_n   (src_rst_n),
    .src_load_i  (src_load_i),
    .src_data_i  (src_data_i),
    .src_busy_o  (src_busy_o),
    .dst_clk     (dst_clk),
    .dst_rst_n   (dst_rst_n),
    .dst_data_o  (dst_data_o),
    .dst_valid_o (dst_valid_o)
  );

  int checks = 0;
  int errors = 0;
  int accepted = 0;
  int delivered = 0;
  bit running = 1'b0;
  bit waiting = 1'b0;
  int wait_cnt = 0;
  bit prev_valid = 1'b0;
  logic [DW-1:0] last_word = '0;
  logic [DW-1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // destination-side reference comparison
  always @(negedge dst_clk) begin
    if (running) begin
      if (dst_valid_o) begin
        chk(!prev_valid, "R6 pulse width", 1, 0);
        chk(exp_q.size() > 0, "R6 unexpected pulse", exp_q.size(), 1);
        if (exp_q.size() > 0) begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(dst_data_o == e, "R5 captured word", dst_data_o, e);
        end
        chk(src_busy_o == 1'b1, "R7 busy during delivery", src_busy_o, 1);
        delivered++;
        last_word = dst_data_o;
        waiting = 1'b0;
      end else begin
        chk(dst_data_o == last_word, "R5 data hold", dst_data_o, last_word);
      end
      if (waiting) begin
        wait_cnt++;
        if (wait_cnt == MAX_LAT + 1) chk(1'b0, "R8 latency", wait_cnt, MAX_LAT);
      end
      prev_valid = dst_valid_o;
    end
  end

  // source-side: busy must cover every undelivered word
  always @(negedge src_clk) begin
    if (running && (accepted != delivered))
      chk(src_busy_o == 1'b1, "R7 busy while open", src_busy_o, 1);
  end

  task automatic send(input logic [DW-1:0] w, input int junk);
    @(negedge src_clk);
    while (src_busy_o) @(negedge src_clk);
    src_load_i = 1'b1;
    src_data_i = w;
    @(negedge src_clk);
    src_load_i = 1'b0;
    chk(src_busy_o == 1'b1, "R2 busy after load", src_busy_o, 1);
    exp_q.push_back(w);
    accepted++;
    wait_cnt = 0;
    waiting = 1'b1;
    for (int j = 0; j < junk; j++) begin
      src_load_i = 1'b1;
      src_data_i = ~w ^ DW'(j * 16'h1357);
      @(negedge src_clk);
    end
    src_load_i = 1'b0;
    if (junk > 0) chk(src_busy_o == 1'b1, "R3 still busy after extra loads", src_busy_o, 1);
  endtask

  task automatic drain();
    @(negedge src_clk);
    while (src_busy_o) @(negedge src_clk);
    repeat (4) @(negedge dst_clk);
    chk(delivered == accepted, "R6 one pulse per load", delivered, accepted);
    chk(exp_q.size() == 0, "R3 no extra words", exp_q.size(), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge src_clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge dst_clk);
    chk(src_busy_o == 1'b0, "R1 busy in reset", src_busy_o, 0);
    chk(dst_valid_o == 1'b0, "R1 valid in reset", dst_valid_o, 0);
    chk(dst_data_o == '0, "R1 data in reset", dst_data_o, 0);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    repeat (4) @(negedge dst_clk);
    chk(src_busy_o == 1'b0, "R1 busy after reset", src_busy_o, 0);
    chk(dst_valid_o == 1'b0, "R1 valid after reset", dst_valid_o, 0);
    chk(dst_data_o == '0, "R1 data after reset", dst_data_o, 0);
    running = 1'b1;

    send(16'hFFFF, 0);
    drain();
    send(16'h0000, 0);
    drain();
    send(16'hA5A5, 3);   // R3 loads while busy
    drain();
    send(16'h5A5A, 5);
    drain();
    // R7 back-to-back: next load in the first idle cycle
    for (int k = 0; k < 12; k++) send(DW'($urandom), k % 3);
    drain();
    for (int k = 0; k < 8; k++) begin
      send(DW'($urandom), 2);
      repeat (k) @(negedge dst_clk);
    end
    drain();

    running = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule